// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Select

This block counts edges on an external pulse pin in a 16-bit accumulator and keeps two sticky flags with an interrupt request for each. One flag records an overflow and the other records an input edge. The same block also chooses which single-cycle enable advances a separate timer counter. The choices are the timer's own prescaler tick, every counted pulse, every 256th counted pulse, or every 65536th counted pulse.

Software reaches the block through a small synchronous register bus. Address 0 holds the control bits, address 1 the flags and address 2 the count. An external 8-bit accumulator can raise the overflow flag through a one-cycle strobe. All clocks in the block are modelled as enables in one clock domain. The reset input is asserted asynchronously and is expected to be released already synchronized to the clock.

Top module: `pulse_acc_top`

## Requirements
- R1: After reset the control register, the flag register and the count read as zero, and `tmr_tick`, `ovf_irq` and `edge_irq` are low while `presc_tick` is low.
- R2: With the accumulator enabled (control bit 0 = 1), the clock source field (control bits 3:2) selects `tmr_tick`. Value 0 selects `presc_tick`. Value 1 selects one tick per counted edge. Value 2 selects a tick on each counted edge that carries out of the low byte. Value 3 selects a tick on each counted edge that wraps the count from 0xFFFF to 0.
- R3: While control bit 0 is 0, `tmr_tick` follows `presc_tick` for any clock source value, and the count does not change except by a bus write.
- R4: A write to the control register changes the source used by `tmr_tick` from the next cycle onward, with no further delay.
- R5: The pin passes through two synchronizer flops. Each active edge adds one to the count in the cycle after it leaves the second flop. Control bit 1 selects the active edge: 0 means rising and 1 means falling.
- R6: Flag bit 1 (overflow) is set when the count wraps from 0xFFFF to 0. It is also set when `ext_ovf8` is high in a cycle, whether or not the accumulator is enabled.
- R7: Flag bit 0 (input) is set by each active edge detected while the accumulator is enabled.
- R8: Writing the flag register clears flag bit 1 when data bit 1 is 1 and flag bit 0 when data bit 0 is 1. Flags whose data bit is 0 are left unchanged, and flag register bits 15:2 read as zero.
- R9: When control bit 6 (fast clear) is 1, any read or write of the count register clears both flags.
- R10: When a flag is set and cleared in the same cycle, it ends up set.
- R11: A write to the count register loads the written value. An edge counted in that same cycle is lost and produces no divided tick.
- R12: `ovf_irq` is high while flag bit 1 and control bit 4 are both 1. `edge_irq` is high while flag bit 0 and control bit 5 are both 1.
- R13: A read returns the control register at address 0 in bits 6:0, the flags at address 1 and the count at address 2. Address 3 reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| pin_in | input | 1 | Asynchronous pulse input |
| presc_tick | input | 1 | Prescaler tick from the timer |
| ext_ovf8 | input | 1 | One-cycle wrap strobe from the external 8-bit accumulator |
| tmr_tick | output | 1 | Selected enable for the timer counter |
| ovf_irq | output | 1 | Overflow interrupt request |
| edge_irq | output | 1 | Input-edge interrupt request |

## Verification
The assertions assume that a bus read and a bus write never target the count in the same cycle in a way that matters. Only the write loads the count, and both kinds of access trigger the fast clear. The assertions also assume that `pin_in` is held steady for at least one clock between changes, so that a polarity write and a real edge are not confused. The bench drives the pin and every bus strobe only on the falling clock edge. Its random phase holds the pin for whole cycles and mixes writes to all four addresses, so that polarity changes, count loads and fast clears all land next to live edges.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;

  typedef enum logic [1:0] {
    SRC_PRESC = 2'b00,
    SRC_EDGE  = 2'b01,
    SRC_DIVLO = 2'b10,
    SRC_DIVHI = 2'b11
  } clk_src_e;

  // Control register layout, MSB first: bit 6 down to bit 0
  typedef struct packed {
    logic     fast_clr;
    logic     edge_ie;
    logic     ovf_ie;
    clk_src_e src;
    logic     falling;
    logic     enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pacc_edge_det.sv
module pacc_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic falling,
  input  logic enable,
  output logic edge_pulse
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q, chain_d;
  logic               cur_lvl, prev_lvl;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign cur_lvl    = chain_q[SYNC_STAGES-1];
  assign prev_lvl   = chain_q[SYNC_STAGES];
  assign edge_pulse = enable & (falling ? (~cur_lvl & prev_lvl) : (cur_lvl & ~prev_lvl));

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pulse ##1 $stable(falling)) |-> !edge_pulse) else $error("edge twice in a row"); // R5
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             low_carry,
  output logic             full_wrap
);
  localparam int LOW_W = CNT_W / 2;

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (load)        cnt_d = load_val;
    else if (cnt_en) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign low_carry = cnt_en & ~load & (&cnt[LOW_W-1:0]);
  assign full_wrap = cnt_en & ~load & (&cnt);

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val)) else $error("load lost"); // R11
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !cnt_en) |=> $stable(cnt)) else $error("count moved"); // R5
  AST_DIV_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    full_wrap |-> low_carry) else $error("wrap without low carry"); // R2
endmodule

// File: rtl/pacc_flags.sv
module pacc_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_set,
  input  logic ovf_clr,
  input  logic edge_set,
  input  logic edge_clr,
  output logic ovf_flag,
  output logic edge_flag
);
  logic ovf_d, edge_d;

  always_comb begin
    ovf_d  = ovf_set  | (ovf_flag  & ~ovf_clr);
    edge_d = edge_set | (edge_flag & ~edge_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag  <= 1'b0;
      edge_flag <= 1'b0;
    end else begin
      ovf_flag  <= ovf_d;
      edge_flag <= edge_d;
    end
  end

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_flag) else $error("overflow set lost"); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_set && edge_clr) |=> edge_flag) else $error("clear beat set"); // R10
endmodule

// File: rtl/pulse_acc_top.sv
module pulse_acc_top
  import pacc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              pin_in,
  input  logic              presc_tick,
  input  logic              ext_ovf8,
  output logic              tmr_tick,
  output logic              ovf_irq,
  output logic              edge_irq
);
  ctrl_t            ctrl_q, ctrl_d;
  logic             wr_ctrl, wr_flag, wr_cnt, cnt_access;
  logic             edge_pulse, cnt_en;
  logic [CNT_W-1:0] cnt;
  logic             low_carry, full_wrap;
  logic             ovf_set, ovf_clr, edge_clr;
  logic             ovf_flag, edge_flag;

  assign wr_ctrl    = bus_wr & (bus_addr == ADDR_CTRL);
  assign wr_flag    = bus_wr & (bus_addr == ADDR_FLAG);
  assign wr_cnt     = bus_wr & (bus_addr == ADDR_CNT);
  assign cnt_access = (bus_wr | bus_rd) & (bus_addr == ADDR_CNT);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  pacc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin        (pin_in),
    .falling    (ctrl_q.falling),
    .enable     (ctrl_q.enable),
    .edge_pulse (edge_pulse)
  );

  assign cnt_en = edge_pulse & ~wr_cnt;

  pacc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .load      (wr_cnt),
    .load_val  (bus_wdata),
    .cnt       (cnt),
    .low_carry (low_carry),
    .full_wrap (full_wrap)
  );

  assign ovf_set  = full_wrap | ext_ovf8;
  assign ovf_clr  = (wr_flag & bus_wdata[1]) | (ctrl_q.fast_clr & cnt_access);
  assign edge_clr = (wr_flag & bus_wdata[0]) | (ctrl_q.fast_clr & cnt_access);

  pacc_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovf_set   (ovf_set),
    .ovf_clr   (ovf_clr),
    .edge_set  (edge_pulse),
    .edge_clr  (edge_clr),
    .ovf_flag  (ovf_flag),
    .edge_flag (edge_flag)
  );

  always_comb begin
    if (!ctrl_q.enable) tmr_tick = presc_tick;
    else begin
      unique case (ctrl_q.src)
        SRC_PRESC: tmr_tick = presc_tick;
        SRC_EDGE:  tmr_tick = cnt_en;
        SRC_DIVLO: tmr_tick = low_carry;
        SRC_DIVHI: tmr_tick = full_wrap;
        default:   tmr_tick = presc_tick;
      endcase
    end
  end

  assign ovf_irq  = ovf_flag  & ctrl_q.ovf_ie;
  assign edge_irq = edge_flag & ctrl_q.edge_ie;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
      ADDR_FLAG: bus_rdata[1:0]        = {ovf_flag, edge_flag};
      ADDR_CNT:  bus_rdata             = cnt;
      default:   bus_rdata             = '0;
    endcase
  end

  AST_FAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.fast_clr && cnt_access && !ovf_set) |=> !ovf_flag) else $error("fast clear missed"); // R9
  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.enable && !wr_cnt) |=> $stable(cnt)) else $error("count moved while off"); // R3
endmodule

// File: tb/tb_pulse_acc_top.sv
module tb_pulse_acc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        pin_in = 1'b0, presc_tick = 1'b0, ext_ovf8 = 1'b0;
  logic        tmr_tick, ovf_irq, edge_irq;

  int    n_checks = 0;
  int    n_errors = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #2 clk = ~clk;

  pulse_acc_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .presc_tick(presc_tick),
    .ext_ovf8(ext_ovf8), .tmr_tick(tmr_tick), .ovf_irq(ovf_irq), .edge_irq(edge_irq)
  );

  // Behavioural reference state
  bit        m_p1, m_p2, m_p3;
  int        m_cnt;
  bit        m_ovf, m_edg;
  bit [6:0]  m_ctrl;

  function automatic bit m_edge_now();
    if (!m_ctrl[0]) return 1'b0;
    if (m_ctrl[1]) return (m_p3 == 1'b1) && (m_p2 == 1'b0);
    return (m_p3 == 1'b0) && (m_p2 == 1'b1);
  endfunction

  function automatic bit m_counts();
    return m_edge_now() && !(bus_wr && bus_addr == 2'd2);
  endfunction

  function automatic bit m_tick();
    if (!m_ctrl[0]) return presc_tick;
    case (m_ctrl[3:2])
      2'd0: return presc_tick;
      2'd1: return m_counts();
      2'd2: return m_counts() && (m_cnt % 256 == 255);
      default: return m_counts() && (m_cnt == 65535);
    endcase
  endfunction

  function automatic int m_read();
    case (bus_addr)
      2'd0: return int'(m_ctrl);
      2'd1: return (int'(m_ovf) << 1) | int'(m_edg);
      2'd2: return m_cnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 = 0; m_p2 = 0; m_p3 = 0; m_cnt = 0; m_ovf = 0; m_edg = 0; m_ctrl = '0;
    end else begin
      bit edge_v, cnt_v, wrap_v, acc_v, oclr, eclr;
      edge_v = m_edge_now();
      cnt_v  = m_counts();
      wrap_v = cnt_v && (m_cnt == 65535);
      acc_v  = (bus_wr || bus_rd) && bus_addr == 2'd2;
      oclr   = (bus_wr && bus_addr == 2'd1 && bus_wdata[1]) || (m_ctrl[6] && acc_v);
      eclr   = (bus_wr && bus_addr == 2'd1 && bus_wdata[0]) || (m_ctrl[6] && acc_v);
      // set has priority over clear (R10)
      m_ovf  = (wrap_v || ext_ovf8) ? 1'b1 : (oclr ? 1'b0 : m_ovf);
      m_edg  = edge_v ? 1'b1 : (eclr ? 1'b0 : m_edg);
      if (bus_wr && bus_addr == 2'd2) m_cnt = int'(bus_wdata);
      else if (cnt_v) m_cnt = (m_cnt + 1) % 65536;
      if (bus_wr && bus_addr == 2'd0) m_ctrl = bus_wdata[6:0];
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = pin_in;
    end
  end

  task automatic check(string name, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic step(bit wr, bit rd, bit [1:0] a, bit [15:0] d, bit pin, bit pt, bit eo);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    pin_in = pin; presc_tick = pt; ext_ovf8 = eo;
    #1;
    check("tmr_tick", int'(tmr_tick), int'(m_tick()));
    check("ovf_irq",  int'(ovf_irq),  int'(m_ovf && m_ctrl[4]));
    check("edge_irq", int'(edge_irq), int'(m_edg && m_ctrl[5]));
    check("rdata",    int'(bus_rdata), m_read());
  endtask

  task automatic idle(bit pin, int n);
    for (int i = 0; i < n; i++) step(0, 1, 2'd2, 16'd0, pin, i[0], 0);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      step(0, 1, 2'd2, 16'd0, 1, 0, 0);
      step(0, 1, 2'd1, 16'd0, 0, 0, 0);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    #1;
    check("reset_tick", int'(tmr_tick), 0);
    check("reset_irq", int'(ovf_irq | edge_irq), 0);
    rst_n = 1'b1;
    step(0, 1, 2'd0, 0, 0, 0, 0);
    step(0, 1, 2'd1, 0, 0, 0, 0);
    step(0, 1, 2'd2, 0, 0, 0, 0);

    tag = "R3";   // disabled: prescaler tick whatever the source
    step(1, 0, 2'd0, 16'h000C, 0, 0, 0);
    idle(1, 4); idle(0, 4);
    pulses(3);

    tag = "R2 R5 R7 R12";   // enabled, per-edge source, rising, both irqs on
    step(1, 0, 2'd0, 16'h0035, 0, 1, 0);
    pulses(5);
    idle(0, 3);

    tag = "R5";   // falling polarity
    step(1, 0, 2'd0, 16'h0007, 0, 0, 0);
    pulses(4);
    idle(0, 3);

    tag = "R4 R2";   // switch to prescaler source and back while ticking
    step(1, 0, 2'd0, 16'h0031, 0, 1, 0);
    step(0, 1, 2'd0, 0, 0, 1, 0);
    step(1, 0, 2'd0, 16'h0035, 0, 1, 0);
    step(0, 1, 2'd0, 0, 0, 1, 0);

    tag = "R8";   // W1C of the input flag only, then read upper bits
    step(1, 0, 2'd1, 16'hFFFC, 0, 0, 0);
    step(1, 0, 2'd1, 16'h0001, 0, 0, 0);
    step(0, 1, 2'd1, 0, 0, 0, 0);

    tag = "R11 R2";   // load near low-byte carry, div256 source
    step(1, 0, 2'd0, 16'h0039, 0, 0, 0);
    step(1, 0, 2'd2, 16'h00FD, 0, 0, 0);
    pulses(4);
    idle(0, 3);

    tag = "R6 R2 R12";   // 16-bit wrap with div65536 source
    step(1, 0, 2'd0, 16'h003D, 0, 0, 0);
    step(1, 0, 2'd2, 16'hFFFE, 0, 0, 0);
    pulses(4);
    idle(0, 3);

    tag = "R8";
    step(1, 0, 2'd1, 16'h0002, 0, 0, 0);
    step(0, 1, 2'd1, 0, 0, 0, 0);

    tag = "R6";   // external strobe while disabled
    step(1, 0, 2'd0, 16'h0010, 0, 0, 0);
    step(0, 0, 2'd1, 0, 0, 0, 1);
    step(0, 1, 2'd1, 0, 0, 0, 0);

    tag = "R10";   // set and clear together
    step(1, 0, 2'd1, 16'h0002, 0, 0, 1);
    step(0, 1, 2'd1, 0, 0, 0, 0);

    tag = "R9";   // fast clear by read of count
    step(1, 0, 2'd0, 16'h0071, 0, 0, 0);
    pulses(2);
    idle(0, 3);
    step(0, 1, 2'd2, 0, 0, 0, 0);
    step(0, 1, 2'd1, 0, 0, 0, 0);

    tag = "R11";   // count write on the edge cycle drops the edge
    step(1, 0, 2'd0, 16'h0005, 0, 0, 0);
    step(0, 1, 2'd1, 0, 1, 0, 0);
    step(0, 1, 2'd1, 0, 1, 0, 0);
    step(1, 0, 2'd2, 16'h1234, 1, 0, 0);
    step(0, 1, 2'd2, 0, 1, 0, 0);

    tag = "R13";   // unused address
    step(1, 0, 2'd3, 16'hFFFF, 0, 0, 0);
    step(0, 1, 2'd3, 0, 0, 0, 0);
    step(0, 1, 2'd0, 0, 0, 0, 0);
    step(0, 1, 2'd2, 0, 0, 0, 0);

    tag = "R2 R6 R9 R10 R11 R13";   // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit [15:0] d;
      r = int'($urandom_range(0, 99));
      d = 16'($urandom);
      if (r < 4)       d = {9'd0, d[6:0]};
      else if (r < 7)  d = 16'hFFF0 | d[3:0];
      step(r < 12, r >= 12 && r < 40, 2'($urandom), d,
           (i % 6) < 3, ($urandom_range(0, 3) == 0), ($urandom_range(0, 30) == 0));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule